// File: doc/BRIEF.md
# Batched Register Access Engine

This block sits on the controller side of a host mailbox and executes one power-register access message at a time. A message has an opcode, a sub-command, a byte count and a 16-byte payload. The payload holds a packed list of byte records. Each record names a 16-bit register address and carries the data for one access to a local file of 8-bit registers. The engine walks the records in order and drives one register-file access per cycle. The access is a plain write, a read, or a masked read-modify-write, depending on the sub-command.

When a message is accepted, the response buffer is loaded with a copy of the payload. Each read then overwrites the data slot of its own record, so software finds every result beside the address it asked for. A message with a wrong opcode, an unknown sub-command or an inconsistent byte count is rejected before any register is touched. Every accepted message ends with a one-cycle done pulse, which carries an error flag and an error code.

Top module: `batch_reg_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `err`, `err_code`, `rf_we`, `rf_re` and `resp` are all zero.
- R2: An accepted start with an opcode other than 0xFF, or with a sub-command above 2, ends with `done`=1, `err`=1 and `err_code`=0x02. `done` rises in the cycle right after the start edge, and no register access takes place. This check takes priority over the size check.
- R3: Record length is 3 bytes for sub-commands 0 (write) and 1 (read), and 4 bytes for sub-command 2 (masked update). An error is raised when the size is not a multiple of the record length, implies more than 5 records, or exceeds 16 bytes. This error gives `err_code`=0x01, no register access, and `done` in the cycle right after the start edge.
- R4: Write records are laid out as address low byte at offset 3n, address high byte at 3n+1 and data at 3n+2. Payload byte k occupies bits 8k+7:8k. Each record writes its data byte to its address.
- R5: Read records use the same layout. The register value read for record n is placed in response byte 2+3n. Every other response byte equals the corresponding payload byte.
- R6: Masked-update records are laid out as address low at 4n, address high at 4n+1, value at 4n+2 and mask at 4n+3. The register becomes (old AND NOT mask) OR (value AND mask). The engine spends one read cycle followed by one write cycle on the same address.
- R7: Records are executed strictly in payload order, one register access per cycle. A later record that names the same register sees the effect of the earlier ones.
- R8: `done` is high for exactly one cycle, and `err` is 0 on success. Counting the start edge as edge 0, `done` appears after edge A, where A is the number of register accesses. A valid message with zero records therefore ends right after the start edge.
- R9: A start pulse while `busy` is high is ignored. The running message completes exactly as if the pulse had not occurred.
- R10: `rf_we` and `rf_re` are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Message strobe, sampled only while idle |
| opcode | input | 8 | Message opcode; 0xFF selects register access |
| subcmd | input | 4 | 0 write, 1 read, 2 masked update |
| size | input | 8 | Payload byte count |
| payload | input | 128 | Packed record bytes, byte k at bits 8k+7:8k |
| resp | output | 128 | Response buffer, same byte layout |
| busy | output | 1 | Message in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| err_code | output | 8 | 0x01 size error, 0x02 command error, valid with done |
| rf_addr | output | 16 | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 8 | Register-file write data |
| rf_re | output | 1 | Register-file read enable |
| rf_rdata | input | 8 | Register-file read data, combinational from rf_addr |

## Verification
The hardest situation to reach is a sequence in which records depend on each other. Examples are two masked updates to the same register, or a read that follows a write to the same address within one message. Only these cases expose reordering or a stale read-back value. The stimulus forces repeated addresses into alternate rounds of the record sweep. The bench's register model also folds the 16-bit address space onto 256 slots, so distinct addresses collide as well. The per-message expectation is computed record by record against a snapshot of that model. The address and kind of every access are logged and compared in order.

// File: rtl/batch_reg_engine.sv
module batch_reg_engine #(
  parameter int          MAX_ENTRIES = 5,
  parameter int          BUF_BYTES   = 16,
  parameter logic [7:0]  MSG_OPCODE  = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             opcode,
  input  logic [3:0]             subcmd,
  input  logic [7:0]             size,
  input  logic [BUF_BYTES*8-1:0] payload,
  output logic [BUF_BYTES*8-1:0] resp,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             err_code,
  output logic [15:0]            rf_addr,
  output logic                   rf_we,
  output logic [7:0]             rf_wdata,
  output logic                   rf_re,
  input  logic [7:0]             rf_rdata
);

  localparam int BUF_W = BUF_BYTES * 8;
  localparam int IDX_W = $clog2(MAX_ENTRIES + 1);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam int EB_W  = OFF_W + 1;
  localparam logic [1:0] SUB_WR  = 2'd0;
  localparam logic [1:0] SUB_RD  = 2'd1;
  localparam logic [1:0] SUB_RMW = 2'd2;
  localparam logic [7:0] CODE_SIZE = 8'h01;
  localparam logic [7:0] CODE_CMD  = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t           state_q;
  logic [BUF_W-1:0] buf_q, resp_q;
  logic [1:0]       sub_q;
  logic [IDX_W-1:0] cnt_q, idx_q;
  logic             ph_q;
  logic [7:0]       old_q;
  logic             err_q;
  logic [7:0]       code_q;

  function automatic logic [7:0] byte_at(input logic [BUF_W-1:0] b, input logic [EB_W-1:0] off);
    return b[8*off[OFF_W-1:0] +: 8];
  endfunction

  // Incoming message decode (R2, R3)
  logic       in_rmw, bad_cmd, bad_size;
  logic [7:0] quot, rem;

  assign in_rmw   = subcmd == 4'd2;
  assign bad_cmd  = (opcode != MSG_OPCODE) || (subcmd > 4'd2);
  assign quot     = in_rmw ? (size >> 2) : (size / 8'd3);
  assign rem      = in_rmw ? {6'b0, size[1:0]} : (size % 8'd3);
  assign bad_size = (rem != 8'd0) || (quot > 8'(MAX_ENTRIES)) || (size > 8'(BUF_BYTES));

  // Current record fields (R4, R5, R6)
  logic             run, is_rmw, last_step;
  logic [EB_W-1:0]  e_base;
  logic [7:0]       f_val, f_msk;

  assign run     = state_q == S_RUN;
  assign is_rmw  = sub_q == SUB_RMW;
  assign e_base  = EB_W'(idx_q) * (is_rmw ? EB_W'(4) : EB_W'(3));
  assign f_val   = byte_at(buf_q, e_base + EB_W'(2));
  assign f_msk   = byte_at(buf_q, e_base + EB_W'(3));
  assign rf_addr = {byte_at(buf_q, e_base + EB_W'(1)), byte_at(buf_q, e_base)};

  // One access per cycle; masked update reads then writes (R6, R7, R10)
  assign rf_re    = run && ((sub_q == SUB_RD) || (is_rmw && !ph_q));
  assign rf_we    = run && ((sub_q == SUB_WR) || (is_rmw && ph_q));
  assign rf_wdata = is_rmw ? ((old_q & ~f_msk) | (f_val & f_msk)) : f_val;

  assign last_step = (idx_q == cnt_q - IDX_W'(1)) && (!is_rmw || ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
      resp_q  <= '0;
      sub_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      ph_q    <= 1'b0;
      old_q   <= '0;
      err_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          buf_q  <= payload;
          resp_q <= payload;
          sub_q  <= subcmd[1:0];
          cnt_q  <= quot[IDX_W-1:0];
          idx_q  <= '0;
          ph_q   <= 1'b0;
          if (bad_cmd) begin
            err_q <= 1'b1; code_q <= CODE_CMD; state_q <= S_DONE;
          end else if (bad_size) begin
            err_q <= 1'b1; code_q <= CODE_SIZE; state_q <= S_DONE;
          end else begin
            err_q   <= 1'b0;
            code_q  <= '0;
            state_q <= (quot == 8'd0) ? S_DONE : S_RUN;
          end
        end
        S_RUN: begin
          if (is_rmw && !ph_q) begin
            ph_q  <= 1'b1;
            old_q <= rf_rdata;
          end else begin
            ph_q  <= 1'b0;
            idx_q <= idx_q + IDX_W'(1);
            if (last_step) state_q <= S_DONE;
          end
          for (int k = 0; k < BUF_BYTES; k++)
            if ((sub_q == SUB_RD) && (EB_W'(k) == e_base + EB_W'(2)))
              resp_q[8*k +: 8] <= rf_rdata;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: completion pulse and status
  assign busy     = state_q != S_IDLE;
  assign done     = state_q == S_DONE;
  assign err      = done && err_q;
  assign err_code = done ? code_q : 8'h00;
  assign resp     = resp_q;

endmodule

module batch_reg_engine_chk #(
  parameter logic [7:0] MSG_OPCODE = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] opcode,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       rf_we,
  input logic       rf_re
);

  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, rf_re}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rf_we && !rf_re));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_bad_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opcode != MSG_OPCODE) |=> (done && err && !rf_we && !rf_re));

  assert_busy_before_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> busy);

endmodule

bind batch_reg_engine batch_reg_engine_chk #(.MSG_OPCODE(MSG_OPCODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .busy(busy),
  .done(done), .err(err), .rf_we(rf_we), .rf_re(rf_re)
);

// File: tb/batch_reg_engine_bench.sv
`timescale 1ns/1ps
module batch_reg_engine_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [7:0]   opcode;
  logic [3:0]   subcmd;
  logic [7:0]   size;
  logic [127:0] payload;
  logic [127:0] resp;
  logic         busy, done, err;
  logic [7:0]   err_code;
  logic [15:0]  rf_addr;
  logic         rf_we, rf_re;
  logic [7:0]   rf_wdata, rf_rdata;

  always #2.5 clk = ~clk;

  batch_reg_engine u_batch_reg_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .subcmd(subcmd),
    .size(size), .payload(payload), .resp(resp), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] hidx(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  logic [7:0]  mem [256];
  logic [16:0] acc_log [$];

  assign rf_rdata = mem[hidx(rf_addr)];

  always @(posedge clk) begin
    if (rf_we) mem[hidx(rf_addr)] <= rf_wdata;
    if (rf_we || rf_re) acc_log.push_back({rf_we, rf_addr});
  end

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1234abcd;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic rand_pl(output logic [127:0] pl);
    for (int w = 0; w < 4; w++) begin
      rng = nxt(rng);
      pl[32*w +: 32] = rng;
    end
  endtask

  task automatic run_msg(input logic [7:0] op, input logic [3:0] sc, input logic [7:0] sz,
                         input logic [127:0] pl, input string req, input bit inject);
    logic [7:0]   em [256];
    logic [127:0] er;
    logic [16:0]  elog [$];
    bit           eerr;
    int           ecode, len, n, lat, bad;
    em = mem; er = pl; len = (sc == 4'd2) ? 4 : 3; ecode = 0; eerr = 0;
    if (op != 8'hFF || sc > 4'd2) begin eerr = 1; ecode = 2; end
    else if ((int'(sz) % len) != 0 || (int'(sz) / len) > 5 || sz > 8'd16) begin eerr = 1; ecode = 1; end
    else begin
      n = int'(sz) / len;
      for (int e = 0; e < n; e++) begin
        int b = e * len;
        logic [15:0] a = {pl[8*(b+1) +: 8], pl[8*b +: 8]};
        logic [7:0]  v = pl[8*(b+2) +: 8];
        if (sc == 4'd0) begin em[hidx(a)] = v; elog.push_back({1'b1, a}); end
        else if (sc == 4'd1) begin er[8*(b+2) +: 8] = em[hidx(a)]; elog.push_back({1'b0, a}); end
        else begin
          logic [7:0] m = pl[8*(b+3) +: 8];
          elog.push_back({1'b0, a}); elog.push_back({1'b1, a});
          em[hidx(a)] = (em[hidx(a)] & ~m) | (v & m);
        end
      end
    end
    @(negedge clk);
    opcode = op; subcmd = sc; size = sz; payload = pl; start = 1'b1;
    acc_log.delete();
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (inject) begin start = 1'b1; opcode = 8'hFF; subcmd = 4'd1; payload = ~pl; end
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(lat == elog.size(), req, "done latency (R8)", 128'(lat), 128'(elog.size()));
    chk(err == eerr && err_code == 8'(ecode), req, "err/code", {err, err_code}, {eerr, 8'(ecode)});
    chk(resp == er, req, "response buffer (R5)", resp, er);
    @(negedge clk);
    chk(!done && !busy, req, "done pulse width (R8)", {done, busy}, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) bad++;
    chk(bad == 0, req, "register file contents", 128'(bad), 0);
    bad = (acc_log.size() != elog.size()) ? 1 : 0;
    if (bad == 0) for (int i = 0; i < elog.size(); i++) if (acc_log[i] !== elog[i]) bad = 1;
    chk(bad == 0, req, "access order (R7)", 128'(acc_log.size()), 128'(elog.size()));
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [127:0] pl;
    string req;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    rst_n = 1'b0; start = 1'b0; opcode = 0; subcmd = 0; size = 0; payload = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && err_code == 0 && !rf_we && !rf_re && resp == 0,
        "R1", "reset state", {busy, done, err, err_code, rf_we, rf_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && resp == 0, "R1", "idle after reset", {busy, done}, 0);

    // Size sweep per sub-command (R2, R3, R4, R5, R6, R8)
    for (int sc = 0; sc < 4; sc++)
      for (int sz = 0; sz <= 20; sz++) begin
        int len = (sc == 2) ? 4 : 3;
        rand_pl(pl);
        if (sc == 3) req = "R2";
        else if ((sz % len) != 0 || sz / len > 5 || sz > 16) req = "R3";
        else if (sz == 0) req = "R8";
        else if (sc == 0) req = "R4";
        else if (sc == 1) req = "R5";
        else req = "R6";
        run_msg(8'hFF, 4'(sc), 8'(sz), pl, req, 1'b0);
      end

    // Opcode sweep (R2)
    for (int k = 0; k < 16; k++) begin
      rand_pl(pl);
      run_msg(8'(k * 17), 4'd1, 8'd6, pl, "R2", 1'b0);
    end

    // Unknown sub-commands with a bad size too: command error wins (R2)
    for (int sc = 3; sc < 16; sc++) begin
      rand_pl(pl);
      run_msg(8'hFF, 4'(sc), 8'd7, pl, "R2", 1'b0);
    end

    // Dependent records with repeated addresses (R7)
    for (int rep = 0; rep < 6; rep++)
      for (int sc = 0; sc < 3; sc++) begin
        int len = (sc == 2) ? 4 : 3;
        int mx  = (sc == 2) ? 4 : 5;
        for (int n = 1; n <= mx; n++) begin
          rand_pl(pl);
          if (rep % 2 == 1) begin
            pl[8*len +: 16] = pl[15:0];
            if (n > 3) pl[8*3*len +: 16] = pl[15:0];
          end
          run_msg(8'hFF, 4'(sc), 8'(n * len), pl, "R7", 1'b0);
        end
      end

    // Start while busy is ignored (R9)
    for (int sc = 0; sc < 3; sc++) begin
      rand_pl(pl);
      run_msg(8'hFF, 4'(sc), (sc == 2) ? 8'd16 : 8'd15, pl, "R9", 1'b1);
    end

    report();
  end

endmodule